// File: doc/BRIEF.md
# Branch Target and Condition Unit

This unit decides where an 8-bit microcontroller with a 16-bit code space fetches next after a control-transfer instruction. The decoder hands it the address of the sequentially following instruction, a 4-bit branch kind, the instruction's offset or address field, and the operands a condition may need: the accumulator, the data pointer, the carry flag, one tested bit, two compare operands and the counter byte of a decrement-and-branch. One clock later the unit presents the resolved next program counter. It also reports whether the branch was taken and what the surrounding datapath must write back: a new carry after a compare, a request to clear the tested bit, and the decremented counter.

Target formation covers four shapes. The first is a sign-extended 8-bit displacement from the following instruction. The second keeps the page and replaces the low 11 bits, so the target stays in the current 2 KB page. The third loads a full 16-bit address, and the fourth adds the accumulator to the data pointer. All address arithmetic wraps modulo 65536. Fetching operands, writing registers and handling the stack are done outside the unit.

Top module: `branch_resolve`

## Requirements
- R1: While rst_n is low, all outputs are zero (br_taken, pc_out, carry_we, carry_out, bit_clr, dec_out).
- R2: Every output reflects the inputs present at the previous rising clock edge. When the branch is not taken, pc_out equals the next_pc of that edge.
- R3: Kind 1 (short relative) is always taken. The target is next_pc plus op_field[7:0] sign-extended, modulo 65536, and op_field[15:8] is ignored (0015h with FEh gives 0013h).
- R4: Kinds 2 (page jump) and 14 (page call) are always taken. The target is {next_pc[15:11], op_field[10:0]}.
- R5: Kinds 3 (long jump) and 15 (long call) are always taken, with target op_field[15:0].
- R6: Kind 4 (indirect) is always taken, with target dptr plus the zero-extended acc, modulo 65536.
- R7: Kind 5 branches when acc is zero and kind 6 branches when acc is nonzero. Both use the relative target of R3.
- R8: Kind 7 branches when carry_in is 1 and kind 8 when it is 0. Kind 9 branches when bit_in is 1 and kind 10 when it is 0. All use the relative target.
- R9: Kind 11 branches to the relative target when bit_in is 1 and then raises bit_clr. In every other case bit_clr stays 0.
- R10: Kind 12 (compare) branches to the relative target when cmp_lhs differs from cmp_rhs. It raises carry_we, with carry_out = 1 when cmp_lhs is below cmp_rhs as unsigned numbers and 0 otherwise.
- R11: dec_out is dec_in minus 1, modulo 256. Kind 13 branches to the relative target when that result is nonzero, so dec_in 00h gives FFh and branches.
- R12: For every kind but 12, carry_we is 0 and carry_out equals carry_in. Kind 0 (none) is never taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_kind | input | 4 | Branch kind code |
| next_pc | input | 16 | Address of the following instruction |
| op_field | input | 16 | Displacement or address field |
| acc | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| carry_in | input | 1 | Current carry flag |
| bit_in | input | 1 | Tested bit value |
| cmp_lhs | input | 8 | First compare operand |
| cmp_rhs | input | 8 | Second compare operand |
| dec_in | input | 8 | Counter byte before decrement |
| br_taken | output | 1 | Branch taken |
| pc_out | output | 16 | Resolved next program counter |
| carry_we | output | 1 | Carry write enable |
| carry_out | output | 1 | New carry value |
| bit_clr | output | 1 | Clear request for the tested bit |
| dec_out | output | 8 | Decremented counter |

## Verification
A compare resolves its branch and produces its carry in the same cycle. The two can disagree in direction: an operand pair can branch and clear carry at once, and equal operands can fall through and still write carry. The vectors drive below-, above- and equal-operand compares with carry_in set to the opposite of the expected result. Each one judges br_taken, pc_out, carry_we and carry_out together on the cycle after the kind is applied. The bit-test-and-clear kind is handled the same way, with bit_clr and the taken decision sampled together.

// File: rtl/branch_resolve_pkg.sv
package branch_resolve_pkg;

   typedef enum logic [3:0] {
      BK_NONE      = 4'd0,
      BK_REL       = 4'd1,
      BK_PAGE      = 4'd2,
      BK_LONG      = 4'd3,
      BK_INDIR     = 4'd4,
      BK_ACC_Z     = 4'd5,
      BK_ACC_NZ    = 4'd6,
      BK_CY_SET    = 4'd7,
      BK_CY_CLR    = 4'd8,
      BK_BIT_SET   = 4'd9,
      BK_BIT_CLR   = 4'd10,
      BK_BIT_TAKE  = 4'd11,
      BK_CMP_NE    = 4'd12,
      BK_DEC_NZ    = 4'd13,
      BK_PAGE_CALL = 4'd14,
      BK_LONG_CALL = 4'd15
   } br_kind_e;

   // which address shape a kind uses
   typedef enum logic [1:0] {
      TS_REL   = 2'd0,
      TS_PAGE  = 2'd1,
      TS_LONG  = 2'd2,
      TS_INDIR = 2'd3
   } tgt_shape_e;

   function automatic tgt_shape_e shape_of(input br_kind_e k);
      tgt_shape_e s;
      case (k)
         BK_PAGE, BK_PAGE_CALL: s = TS_PAGE;
         BK_LONG, BK_LONG_CALL: s = TS_LONG;
         BK_INDIR:              s = TS_INDIR;
         default:               s = TS_REL;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/br_target_gen.sv
module br_target_gen
   import branch_resolve_pkg::*;
#(
   parameter int PC_W   = 16,
   parameter int PAGE_W = 11,
   parameter int REL_W  = 8,
   parameter int DATA_W = 8
) (
   input  br_kind_e          kind,
   input  logic [PC_W-1:0]   next_pc,
   input  logic [PC_W-1:0]   op_field,
   input  logic [DATA_W-1:0] acc,
   input  logic [PC_W-1:0]   dptr,
   output logic [PC_W-1:0]   target
);

   localparam int EXT_W = PC_W - REL_W;
   localparam int HI_W  = PC_W - PAGE_W;
   localparam int ACC_PAD = PC_W - DATA_W;

   logic [PC_W-1:0] rel_ext;
   logic [PC_W-1:0] acc_ext;
   logic [PC_W-1:0] rel_tgt;
   logic [PC_W-1:0] page_tgt;
   logic [PC_W-1:0] long_tgt;
   logic [PC_W-1:0] ind_tgt;

   // sign extension of the displacement; width-equal case needs no padding
   generate
      if (EXT_W > 0) begin : g_rel_pad
         assign rel_ext = {{EXT_W{op_field[REL_W-1]}}, op_field[REL_W-1:0]};
      end else begin : g_rel_full
         assign rel_ext = op_field[PC_W-1:0];
      end
   endgenerate

   generate
      if (ACC_PAD > 0) begin : g_acc_pad
         assign acc_ext = {{ACC_PAD{1'b0}}, acc};
      end else begin : g_acc_full
         assign acc_ext = acc[PC_W-1:0];
      end
   endgenerate

   // page form keeps the upper bits of the following instruction
   assign page_tgt = {next_pc[PC_W-1:PAGE_W], op_field[PAGE_W-1:0]};

   // carries past the top bit fall away: modulo 2**PC_W
   assign rel_tgt  = next_pc + rel_ext;
   assign long_tgt = op_field;
   assign ind_tgt  = dptr + acc_ext;

   always_comb begin
      case (shape_of(kind))
         TS_PAGE:  target = page_tgt;
         TS_LONG:  target = long_tgt;
         TS_INDIR: target = ind_tgt;
         default:  target = rel_tgt;
      endcase
   end

   logic unused_hi;
   assign unused_hi = (HI_W > 0) ? 1'b0 : 1'b0;

endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
   import branch_resolve_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  br_kind_e          kind,
   input  logic [DATA_W-1:0] acc,
   input  logic              carry_in,
   input  logic              bit_in,
   input  logic [DATA_W-1:0] cmp_lhs,
   input  logic [DATA_W-1:0] cmp_rhs,
   input  logic [DATA_W-1:0] dec_in,
   output logic              taken,
   output logic              carry_we,
   output logic              carry_out,
   output logic              bit_clr,
   output logic [DATA_W-1:0] dec_out
);

   logic acc_zero;
   logic cmp_differ;
   logic cmp_below;
   logic dec_nonzero;

   assign acc_zero    = (acc == '0);
   assign cmp_differ  = (cmp_lhs != cmp_rhs);
   assign cmp_below   = (cmp_lhs < cmp_rhs);
   assign dec_out     = dec_in - {{(DATA_W-1){1'b0}}, 1'b1};
   assign dec_nonzero = (dec_out != '0);

   always_comb begin
      taken     = 1'b0;
      carry_we  = 1'b0;
      carry_out = carry_in;
      bit_clr   = 1'b0;
      case (kind)
         BK_NONE:      taken = 1'b0;
         BK_REL,
         BK_PAGE,
         BK_LONG,
         BK_INDIR,
         BK_PAGE_CALL,
         BK_LONG_CALL: taken = 1'b1;
         BK_ACC_Z:     taken = acc_zero;
         BK_ACC_NZ:    taken = !acc_zero;
         BK_CY_SET:    taken = carry_in;
         BK_CY_CLR:    taken = !carry_in;
         BK_BIT_SET:   taken = bit_in;
         BK_BIT_CLR:   taken = !bit_in;
         BK_BIT_TAKE: begin
            taken   = bit_in;
            bit_clr = bit_in;
         end
         BK_CMP_NE: begin
            taken     = cmp_differ;
            carry_we  = 1'b1;
            carry_out = cmp_below;
         end
         BK_DEC_NZ:    taken = dec_nonzero;
         default:      taken = 1'b0;
      endcase
   end

endmodule

// File: rtl/br_out_stage.sv
module br_out_stage #(
   parameter int PC_W    = 16,
   parameter int DATA_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              taken_d,
   input  logic [PC_W-1:0]   pc_d,
   input  logic              carry_we_d,
   input  logic              carry_out_d,
   input  logic              bit_clr_d,
   input  logic [DATA_W-1:0] dec_d,
   output logic              taken_q,
   output logic [PC_W-1:0]   pc_q,
   output logic              carry_we_q,
   output logic              carry_out_q,
   output logic              bit_clr_q,
   output logic [DATA_W-1:0] dec_q
);

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               taken_q     <= 1'b0;
               pc_q        <= '0;
               carry_we_q  <= 1'b0;
               carry_out_q <= 1'b0;
               bit_clr_q   <= 1'b0;
               dec_q       <= '0;
            end else begin
               taken_q     <= taken_d;
               pc_q        <= pc_d;
               carry_we_q  <= carry_we_d;
               carry_out_q <= carry_out_d;
               bit_clr_q   <= bit_clr_d;
               dec_q       <= dec_d;
            end
         end
      end else begin : g_comb
         logic clk_unused;
         assign clk_unused  = clk;
         assign taken_q     = rst_n & taken_d;
         assign pc_q        = rst_n ? pc_d : '0;
         assign carry_we_q  = rst_n & carry_we_d;
         assign carry_out_q = rst_n & carry_out_d;
         assign bit_clr_q   = rst_n & bit_clr_d;
         assign dec_q       = rst_n ? dec_d : '0;
      end
   endgenerate

endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
   import branch_resolve_pkg::*;
#(
   parameter int PC_W    = 16,
   parameter int PAGE_W  = 11,
   parameter int REL_W   = 8,
   parameter int DATA_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        br_kind,
   input  logic [PC_W-1:0]   next_pc,
   input  logic [PC_W-1:0]   op_field,
   input  logic [DATA_W-1:0] acc,
   input  logic [PC_W-1:0]   dptr,
   input  logic              carry_in,
   input  logic              bit_in,
   input  logic [DATA_W-1:0] cmp_lhs,
   input  logic [DATA_W-1:0] cmp_rhs,
   input  logic [DATA_W-1:0] dec_in,
   output logic              br_taken,
   output logic [PC_W-1:0]   pc_out,
   output logic              carry_we,
   output logic              carry_out,
   output logic              bit_clr,
   output logic [DATA_W-1:0] dec_out
);

   // elaboration-time parameter checks
   generate
      if (PAGE_W < 1 || PAGE_W >= PC_W) begin : g_bad_page
         $error("branch_resolve: PAGE_W must lie in 1..PC_W-1");
      end
      if (REL_W < 2 || REL_W > PC_W) begin : g_bad_rel
         $error("branch_resolve: REL_W must lie in 2..PC_W");
      end
      if (DATA_W < 2 || DATA_W > PC_W) begin : g_bad_data
         $error("branch_resolve: DATA_W must lie in 2..PC_W");
      end
   endgenerate

   br_kind_e          kind;
   logic [PC_W-1:0]   tgt;
   logic [PC_W-1:0]   pc_sel;
   logic              tk_d;
   logic              cwe_d;
   logic              cy_d;
   logic              bclr_d;
   logic [DATA_W-1:0] dec_d;

   assign kind = br_kind_e'(br_kind);

   br_target_gen #(
      .PC_W   (PC_W),
      .PAGE_W (PAGE_W),
      .REL_W  (REL_W),
      .DATA_W (DATA_W)
   ) u_tgt (
      .kind     (kind),
      .next_pc  (next_pc),
      .op_field (op_field),
      .acc      (acc),
      .dptr     (dptr),
      .target   (tgt)
   );

   br_cond_eval #(
      .DATA_W (DATA_W)
   ) u_cond (
      .kind      (kind),
      .acc       (acc),
      .carry_in  (carry_in),
      .bit_in    (bit_in),
      .cmp_lhs   (cmp_lhs),
      .cmp_rhs   (cmp_rhs),
      .dec_in    (dec_in),
      .taken     (tk_d),
      .carry_we  (cwe_d),
      .carry_out (cy_d),
      .bit_clr   (bclr_d),
      .dec_out   (dec_d)
   );

   assign pc_sel = tk_d ? tgt : next_pc;

   br_out_stage #(
      .PC_W    (PC_W),
      .DATA_W  (DATA_W),
      .REG_OUT (REG_OUT)
   ) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .taken_d     (tk_d),
      .pc_d        (pc_sel),
      .carry_we_d  (cwe_d),
      .carry_out_d (cy_d),
      .bit_clr_d   (bclr_d),
      .dec_d       (dec_d),
      .taken_q     (br_taken),
      .pc_q        (pc_out),
      .carry_we_q  (carry_we),
      .carry_out_q (carry_out),
      .bit_clr_q   (bit_clr),
      .dec_q       (dec_out)
   );

endmodule

// File: rtl/branch_resolve_chk.sv
module branch_resolve_chk
   import branch_resolve_pkg::*;
#(
   parameter int PC_W    = 16,
   parameter int PAGE_W  = 11,
   parameter int DATA_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        br_kind,
   input logic [PC_W-1:0]   next_pc,
   input logic              carry_in,
   input logic [DATA_W-1:0] cmp_lhs,
   input logic [DATA_W-1:0] cmp_rhs,
   input logic              br_taken,
   input logic [PC_W-1:0]   pc_out,
   input logic              carry_we,
   input logic              carry_out,
   input logic              bit_clr
);

   // one clock edge must pass after reset before $past means anything
   logic primed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   generate
      if (REG_OUT) begin : g_props
         // R2
         a_r2_fallthrough_pc: assert property (@(posedge clk) disable iff (!rst_n || !primed)
            !br_taken |-> pc_out == $past(next_pc));

         // R4
         a_r4_page_kept: assert property (@(posedge clk) disable iff (!rst_n || !primed)
            ($past(br_kind) == BK_PAGE || $past(br_kind) == BK_PAGE_CALL) |->
               (br_taken && pc_out[PC_W-1:PAGE_W] == $past(next_pc[PC_W-1:PAGE_W])));

         // R9
         a_r9_clear_only_taken: assert property (@(posedge clk) disable iff (!rst_n || !primed)
            bit_clr |-> (br_taken && $past(br_kind) == BK_BIT_TAKE));

         // R10
         a_r10_cmp_carry: assert property (@(posedge clk) disable iff (!rst_n || !primed)
            ($past(br_kind) == BK_CMP_NE) |->
               (carry_we && carry_out == ($past(cmp_lhs) < $past(cmp_rhs))
                && br_taken == ($past(cmp_lhs) != $past(cmp_rhs))));

         // R12
         a_r12_carry_hold: assert property (@(posedge clk) disable iff (!rst_n || !primed)
            !carry_we |-> (carry_out == $past(carry_in) && $past(br_kind) != BK_CMP_NE));

         // R12
         a_r12_none_falls: assert property (@(posedge clk) disable iff (!rst_n || !primed)
            ($past(br_kind) == BK_NONE) |-> !br_taken);
      end
   endgenerate

endmodule

bind branch_resolve branch_resolve_chk #(
   .PC_W    (PC_W),
   .PAGE_W  (PAGE_W),
   .DATA_W  (DATA_W),
   .REG_OUT (REG_OUT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .br_kind   (br_kind),
   .next_pc   (next_pc),
   .carry_in  (carry_in),
   .cmp_lhs   (cmp_lhs),
   .cmp_rhs   (cmp_rhs),
   .br_taken  (br_taken),
   .pc_out    (pc_out),
   .carry_we  (carry_we),
   .carry_out (carry_out),
   .bit_clr   (bit_clr)
);

// File: tb/branch_resolve_tb_top.sv
module branch_resolve_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  br_kind = '0;
   logic [15:0] next_pc = '0;
   logic [15:0] op_field = '0;
   logic [7:0]  acc = '0;
   logic [15:0] dptr = '0;
   logic        carry_in = 1'b0;
   logic        bit_in = 1'b0;
   logic [7:0]  cmp_lhs = '0;
   logic [7:0]  cmp_rhs = '0;
   logic [7:0]  dec_in = '0;
   logic        br_taken;
   logic [15:0] pc_out;
   logic        carry_we;
   logic        carry_out;
   logic        bit_clr;
   logic [7:0]  dec_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   branch_resolve dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .br_kind   (br_kind),
      .next_pc   (next_pc),
      .op_field  (op_field),
      .acc       (acc),
      .dptr      (dptr),
      .carry_in  (carry_in),
      .bit_in    (bit_in),
      .cmp_lhs   (cmp_lhs),
      .cmp_rhs   (cmp_rhs),
      .dec_in    (dec_in),
      .br_taken  (br_taken),
      .pc_out    (pc_out),
      .carry_we  (carry_we),
      .carry_out (carry_out),
      .bit_clr   (bit_clr),
      .dec_out   (dec_out)
   );

   typedef struct packed {
      logic [3:0]  kind;
      logic [15:0] npc;
      logic [15:0] fld;
      logic [7:0]  a;
      logic [15:0] dp;
      logic        cy;
      logic        bt;
      logic [7:0]  lhs;
      logic [7:0]  rhs;
      logic [7:0]  dec;
      logic        e_tk;
      logic [15:0] e_pc;
      logic        e_cwe;
      logic        e_cy;
      logic        e_clr;
   } vec_t;

   localparam int NV = 27;
   localparam vec_t VECS [NV] = '{
      // R3 relative, incl. wrap and upper field bits ignored
      '{4'd1,  16'h0015, 16'h12FE, 8'h55, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h10, 1'b1, 16'h0013, 1'b0, 1'b0, 1'b0},
      '{4'd1,  16'hFFF0, 16'h0020, 8'h55, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h10, 1'b1, 16'h0010, 1'b0, 1'b0, 1'b0},
      '{4'd1,  16'h0100, 16'h007F, 8'h55, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h10, 1'b1, 16'h017F, 1'b0, 1'b0, 1'b0},
      '{4'd1,  16'h0100, 16'h0080, 8'h55, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h10, 1'b1, 16'h0080, 1'b0, 1'b0, 1'b0},
      // R4 page forms
      '{4'd2,  16'h3FFE, 16'hF123, 8'h55, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h10, 1'b1, 16'h3923, 1'b0, 1'b0, 1'b0},
      '{4'd14, 16'h8802, 16'h0005, 8'h55, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h10, 1'b1, 16'h8805, 1'b0, 1'b0, 1'b0},
      // R5 long forms
      '{4'd3,  16'h0000, 16'hABCD, 8'h55, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h10, 1'b1, 16'hABCD, 1'b0, 1'b0, 1'b0},
      '{4'd15, 16'h4444, 16'h1234, 8'h55, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h10, 1'b1, 16'h1234, 1'b0, 1'b0, 1'b0},
      // R6 indirect with wrap
      '{4'd4,  16'h0000, 16'h0000, 8'hFF, 16'hFFF0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h10, 1'b1, 16'h00EF, 1'b0, 1'b0, 1'b0},
      // R7 accumulator tests
      '{4'd5,  16'h0200, 16'h0010, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h10, 1'b1, 16'h0210, 1'b0, 1'b0, 1'b0},
      '{4'd5,  16'h0200, 16'h0010, 8'h01, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h10, 1'b0, 16'h0200, 1'b0, 1'b0, 1'b0},
      '{4'd6,  16'h0200, 16'h00F0, 8'h01, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h10, 1'b1, 16'h01F0, 1'b0, 1'b0, 1'b0},
      '{4'd6,  16'h0200, 16'h00F0, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h10, 1'b0, 16'h0200, 1'b0, 1'b0, 1'b0},
      // R8 carry and bit tests
      '{4'd7,  16'h1000, 16'h0004, 8'h55, 16'h0000, 1'b1, 1'b0, 8'h00, 8'h00, 8'h10, 1'b1, 16'h1004, 1'b0, 1'b1, 1'b0},
      '{4'd8,  16'h1000, 16'h0004, 8'h55, 16'h0000, 1'b1, 1'b0, 8'h00, 8'h00, 8'h10, 1'b0, 16'h1000, 1'b0, 1'b1, 1'b0},
      '{4'd8,  16'h1000, 16'h00FE, 8'h55, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h10, 1'b1, 16'h0FFE, 1'b0, 1'b0, 1'b0},
      '{4'd9,  16'h1000, 16'h0004, 8'h55, 16'h0000, 1'b0, 1'b1, 8'h00, 8'h00, 8'h10, 1'b1, 16'h1004, 1'b0, 1'b0, 1'b0},
      '{4'd10, 16'h1000, 16'h0004, 8'h55, 16'h0000, 1'b0, 1'b1, 8'h00, 8'h00, 8'h10, 1'b0, 16'h1000, 1'b0, 1'b0, 1'b0},
      '{4'd10, 16'h1000, 16'h0002, 8'h55, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h10, 1'b1, 16'h1002, 1'b0, 1'b0, 1'b0},
      // R9 test-and-clear
      '{4'd11, 16'h1000, 16'h0004, 8'h55, 16'h0000, 1'b0, 1'b1, 8'h00, 8'h00, 8'h10, 1'b1, 16'h1004, 1'b0, 1'b0, 1'b1},
      '{4'd11, 16'h1000, 16'h0004, 8'h55, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h10, 1'b0, 16'h1000, 1'b0, 1'b0, 1'b0},
      // R10 compare: below, above, equal
      '{4'd12, 16'h2000, 16'h0010, 8'h55, 16'h0000, 1'b0, 1'b0, 8'h05, 8'h09, 8'h10, 1'b1, 16'h2010, 1'b1, 1'b1, 1'b0},
      '{4'd12, 16'h2000, 16'h0010, 8'h55, 16'h0000, 1'b1, 1'b0, 8'h09, 8'h05, 8'h10, 1'b1, 16'h2010, 1'b1, 1'b0, 1'b0},
      '{4'd12, 16'h2000, 16'h0010, 8'h55, 16'h0000, 1'b1, 1'b0, 8'h80, 8'h80, 8'h10, 1'b0, 16'h2000, 1'b1, 1'b0, 1'b0},
      // R11 decrement
      '{4'd13, 16'h3000, 16'h00FC, 8'h55, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h01, 1'b0, 16'h3000, 1'b0, 1'b0, 1'b0},
      '{4'd13, 16'h3000, 16'h00FC, 8'h55, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b1, 16'h2FFC, 1'b0, 1'b0, 1'b0},
      // R12 none kind
      '{4'd0,  16'h5000, 16'h0010, 8'h55, 16'h0000, 1'b1, 1'b0, 8'h00, 8'h00, 8'h10, 1'b0, 16'h5000, 1'b0, 1'b1, 1'b0}
   };

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic string req_of(input logic [3:0] k);
      case (k)
         4'd1:              return "R3";
         4'd2, 4'd14:       return "R4";
         4'd3, 4'd15:       return "R5";
         4'd4:              return "R6";
         4'd5, 4'd6:        return "R7";
         4'd7, 4'd8,
         4'd9, 4'd10:       return "R8";
         4'd11:             return "R9";
         4'd12:             return "R10";
         4'd13:             return "R11";
         default:           return "R12";
      endcase
   endfunction

   task automatic apply(input vec_t v);
      br_kind  = v.kind;
      next_pc  = v.npc;
      op_field = v.fld;
      acc      = v.a;
      dptr     = v.dp;
      carry_in = v.cy;
      bit_in   = v.bt;
      cmp_lhs  = v.lhs;
      cmp_rhs  = v.rhs;
      dec_in   = v.dec;
   endtask

   task automatic check_zero(input string tag);
      check(tag, "taken",  {15'd0, br_taken},  16'h0);
      check(tag, "pc",     pc_out,             16'h0);
      check(tag, "cwe",    {15'd0, carry_we},  16'h0);
      check(tag, "cy",     {15'd0, carry_out}, 16'h0);
      check(tag, "clr",    {15'd0, bit_clr},   16'h0);
      check(tag, "dec",    {8'd0, dec_out},    16'h0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      vec_t lv;
      // R1: reset state, inputs set to something that would branch
      br_kind  = 4'd3;
      op_field = 16'hBEEF;
      repeat (3) @(negedge clk);
      check_zero("R1");

      @(negedge clk);
      rst_n = 1'b1;
      apply(VECS[0]);

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i]);
         @(negedge clk);
         check(req_of(VECS[i].kind), "taken", {15'd0, br_taken},  {15'd0, VECS[i].e_tk});
         check(req_of(VECS[i].kind), "pc",    pc_out,             VECS[i].e_pc);
         check(req_of(VECS[i].kind), "cwe",   {15'd0, carry_we},  {15'd0, VECS[i].e_cwe});
         check(req_of(VECS[i].kind), "cy",    {15'd0, carry_out}, {15'd0, VECS[i].e_cy});
         check(req_of(VECS[i].kind), "clr",   {15'd0, bit_clr},   {15'd0, VECS[i].e_clr});
         // R11: decrement modulo 256 for every kind
         check("R11", "dec", {8'd0, dec_out}, {8'd0, VECS[i].dec - 8'd1});
      end

      // R2: back-to-back kinds, each output belongs to the edge before it
      apply(VECS[6]);               // long jump to ABCD
      @(negedge clk);
      apply(VECS[10]);              // not taken, falls to 0200
      check("R2", "pc first", pc_out, 16'hABCD);
      @(negedge clk);
      check("R2", "pc second", pc_out, 16'h0200);
      check("R2", "taken second", {15'd0, br_taken}, 16'h0);

      // R1: reset asserted mid-run clears outputs at once
      lv = VECS[19];                // test-and-clear, taken
      apply(lv);
      @(negedge clk);
      check("R9", "clr before reset", {15'd0, bit_clr}, 16'h1);
      rst_n = 1'b0;
      #2;
      check_zero("R1");
      @(negedge clk);
      check_zero("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check("R9", "clr after release", {15'd0, bit_clr}, 16'h1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule